// File: doc/BRIEF.md
# DMA Channel Register and Claim Front End

This block is the register side of a multi-channel memory copy engine. Software reaches each channel through its own 4 KB window. The channel number comes from the address bits above bit 11. Inside a window, software stages a descriptor: a configuration word, a byte count, a destination and a source. It then drives a control word through a claim/run handshake. Read-only mirrors show the descriptor that is in flight. The copy engine updates these mirrors as it makes progress.

A channel has to be claimed before it can run. Claiming a free channel puts its staged descriptor back to defaults. A channel that is running keeps its claim even when software tries to drop it. When a run request is accepted, the block raises a one-cycle start pulse on the channel's start line. In the cycle after the accepting write, it also presents a snapshot of the staged descriptor to the engine. The engine reports completion or failure per channel. Two interrupt lines per channel follow the status bits, each gated by its own enable.

The bus is a 64-bit register port with byte strobes. Only bits 15:3 of the byte address reach the block, so every access covers one 8-byte word. A 32-bit register at offset 4 sits in byte lanes 7:4 of its word. Read data returns one cycle after the request.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, each channel's control word is 0. Its staged config is 0x6600_0000 (read size 6 in bits 31:28, write size 6 in bits 27:24). The staged byte count, destination and source are 0, and so are all in-flight mirrors. No interrupt, start or read-valid output is high.
- R2: A read request returns its data on rdata_o together with rvalid_o one cycle later. rvalid_o is never high without a read in the previous cycle.
- R3: The following write loads the staged config with 0x6600_0000 and zeroes the staged byte count, destination and source:
  - it targets control (word 0x000, lanes 3:0),
  - it sets claim (control bit 0),
  - the channel is unclaimed.
  The same write on a channel that is already claimed leaves the staged registers unchanged.
- R4: Writes update the staged registers only in the byte lanes whose strobe is set. The staged registers are:
  - config: word 0x000, lanes 7:4,
  - byte count: 0x008,
  - destination: 0x010,
  - source: 0x018.
- R5: A control write to a channel that was unclaimed before the write always stores run (bit 1) as 0 and raises no start pulse.
- R6: A start pulse on start_o[n] is raised in the cycle after a control write when all of the following hold:
  - the channel was claimed before the write,
  - the write sets run,
  - run was 0 before the write.
  The pulse lasts exactly one cycle. In that cycle the start_* outputs carry the staged descriptor. The write clears done (bit 30) and error (bit 31).
- R7: A control write that clears claim while run is set keeps claim set.
- R8: A control write that clears claim on a claimed, idle channel releases the channel and stores run as 0.
- R9: An engine done pulse sets done (bit 30) and clears run. An engine error pulse sets error (bit 31) and clears run.
- R10: For channel n, irq_o[2n] is high exactly when done and done-enable (bit 14) are both set. irq_o[2n+1] is high exactly when error and error-enable (bit 15) are both set.
- R11: The in-flight mirrors are:
  - config: word 0x100, lanes 7:4,
  - byte count: 0x108,
  - destination: 0x110,
  - source: 0x118.
  They load from the staged descriptor at start and then follow engine updates. Bus writes to them are ignored.
- R12: Accesses to a channel number at or above NUM_CH, or to an unmapped offset, read as zero and leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W-3 | Byte address bits ADDR_W-1:3 |
| wdata_i | input | 64 | Write data |
| be_i | input | 8 | Byte-lane strobes |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| start_cfg_o | output | 32 | Config snapshot for the engine |
| start_bytes_o | output | 64 | Byte count snapshot |
| start_dst_o | output | 64 | Destination snapshot |
| start_src_o | output | 64 | Source snapshot |
| upd_valid_i | input | 1 | Engine mirror update strobe |
| upd_ch_i | input | IDX_W | Channel of the mirror update |
| upd_cfg_i | input | 32 | Updated in-flight config |
| upd_bytes_i | input | 64 | Remaining byte count |
| upd_dst_i | input | 64 | Current destination |
| upd_src_i | input | 64 | Current source |
| done_i | input | NUM_CH | Engine completion pulse per channel |
| err_i | input | NUM_CH | Engine failure pulse per channel |
| irq_o | output | 2*NUM_CH | Done (even) and error (odd) interrupt lines |

## Verification
The bench covers each of the following corner cases, named by the mistake a wrong design would make:
- **Reclaim clobbers the descriptor.** The bench claims a channel that is already claimed. A design that reloads defaults on every claim write would wipe a descriptor software had staged.
- **Dropped claim while running.** The bench tries to unclaim a running channel. A design without the forced claim would show the channel released mid-transfer.
- **Claim and run in one write on a free channel.** A design that checks claim after the write instead of before would start a transfer here.
- **Repeated run.** The bench writes run again while the channel is running. A design that restarts would emit a second start pulse.
- **Interrupt gating.** The bench clears an enable while status stays set. It also checks that starting a channel drops a stale done line.
- **Stray accesses.** Accesses to a missing channel, to an unmapped offset and to the read-only mirrors must not touch any state a later read can observe.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned STRB_W = BUS_W / 8;
  localparam int unsigned OFF_W  = 9;   // word offset inside a 4 KB window

  localparam logic [OFF_W-1:0] OFF_CTL_CFG = 9'h000;
  localparam logic [OFF_W-1:0] OFF_NBYTES  = 9'h001;
  localparam logic [OFF_W-1:0] OFF_NDST    = 9'h002;
  localparam logic [OFF_W-1:0] OFF_NSRC    = 9'h003;
  localparam logic [OFF_W-1:0] OFF_XCFG    = 9'h020;
  localparam logic [OFF_W-1:0] OFF_XBYTES  = 9'h021;
  localparam logic [OFF_W-1:0] OFF_XDST    = 9'h022;
  localparam logic [OFF_W-1:0] OFF_XSRC    = 9'h023;

  localparam int unsigned CB_CLAIM   = 0;
  localparam int unsigned CB_RUN     = 1;
  localparam int unsigned CB_DONE_IE = 14;
  localparam int unsigned CB_ERR_IE  = 15;
  localparam int unsigned CB_DONE    = 30;
  localparam int unsigned CB_ERR     = 31;

  localparam logic [31:0] CTL_KEEP    = 32'hC000_C003;
  localparam logic [31:0] CFG_DEFAULT = 32'h6600_0000;

  typedef struct packed {
    logic [31:0]      cfg;
    logic [BUS_W-1:0] bytes;
    logic [BUS_W-1:0] dst;
    logic [BUS_W-1:0] src;
  } desc_t;

  localparam desc_t DESC_DEFAULT = '{cfg: CFG_DEFAULT, bytes: '0, dst: '0, src: '0};

  function automatic logic [BUS_W-1:0] strb_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [STRB_W-1:0] be);
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int i = 0; i < int'(STRB_W); i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [STRB_W-1:0] be_i,
  input  logic              upd_i,
  input  desc_t             upd_desc_i,
  input  logic              done_i,
  input  logic              err_i,
  output desc_t             next_o,
  output logic              start_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_done_o,
  output logic              irq_err_o
);
  logic [31:0]      ctl_q, ctl_d, ctl_w;
  desc_t            next_q, next_d, exec_q, exec_d;
  logic [BUS_W-1:0] mrg;
  logic             start;

  always_comb begin
    ctl_d  = ctl_q;
    next_d = next_q;
    exec_d = exec_q;
    start  = 1'b0;
    ctl_w  = '0;
    mrg    = '0;
    if (wr_i) begin
      unique case (off_i)
        OFF_CTL_CFG: begin
          mrg = strb_merge({next_q.cfg, ctl_q}, wdata_i, be_i);
          if (|be_i[7:4]) next_d.cfg = mrg[63:32];
          if (|be_i[3:0]) begin
            ctl_w = mrg[31:0] & CTL_KEEP;
            if (!ctl_q[CB_CLAIM] && ctl_w[CB_CLAIM]) next_d = DESC_DEFAULT;
            // a running channel cannot be released
            if (ctl_q[CB_RUN] && !ctl_w[CB_CLAIM]) ctl_w[CB_CLAIM] = 1'b1;
            if (!ctl_q[CB_CLAIM] || (!ctl_q[CB_RUN] && !ctl_w[CB_CLAIM])) begin
              ctl_w[CB_RUN] = 1'b0;
            end else if (ctl_w[CB_RUN] && !ctl_q[CB_RUN]) begin
              start          = 1'b1;
              ctl_w[CB_DONE] = 1'b0;
              ctl_w[CB_ERR]  = 1'b0;
            end
            ctl_d = ctl_w;
          end
        end
        OFF_NBYTES: next_d.bytes = strb_merge(next_q.bytes, wdata_i, be_i);
        OFF_NDST:   next_d.dst   = strb_merge(next_q.dst, wdata_i, be_i);
        OFF_NSRC:   next_d.src   = strb_merge(next_q.src, wdata_i, be_i);
        default: ;
      endcase
    end
    if (start)      exec_d = next_q;
    else if (upd_i) exec_d = upd_desc_i;
    if (done_i) begin
      ctl_d[CB_DONE] = 1'b1;
      ctl_d[CB_RUN]  = 1'b0;
    end
    if (err_i) begin
      ctl_d[CB_ERR] = 1'b1;
      ctl_d[CB_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      next_q <= DESC_DEFAULT;
      exec_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      next_q <= next_d;
      exec_q <= exec_d;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CTL_CFG: rdata_o = {next_q.cfg, ctl_q};
      OFF_NBYTES:  rdata_o = next_q.bytes;
      OFF_NDST:    rdata_o = next_q.dst;
      OFF_NSRC:    rdata_o = next_q.src;
      OFF_XCFG:    rdata_o = {exec_q.cfg, 32'h0};
      OFF_XBYTES:  rdata_o = exec_q.bytes;
      OFF_XDST:    rdata_o = exec_q.dst;
      OFF_XSRC:    rdata_o = exec_q.src;
      default:     rdata_o = '0;
    endcase
  end

  assign next_o     = next_q;
  assign start_o    = start;
  assign irq_done_o = ctl_q[CB_DONE] & ctl_q[CB_DONE_IE];
  assign irq_err_o  = ctl_q[CB_ERR] & ctl_q[CB_ERR_IE];
endmodule

// File: rtl/dma_start_stage.sv
module dma_start_stage
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] start_i,
  input  desc_t             desc_i,
  output logic [NUM_CH-1:0] start_o,
  output desc_t             desc_o
);
  logic [NUM_CH-1:0] start_q;
  desc_t             desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      desc_q  <= '0;
    end else begin
      start_q <= start_i;
      if (|start_i) desc_q <= desc_i;
    end
  end

  assign start_o = start_q;
  assign desc_o  = desc_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter  int unsigned NUM_CH = 2,
  parameter  int unsigned ADDR_W = 16,
  localparam int unsigned CH_W   = ADDR_W - 12,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:3]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  input  logic [STRB_W-1:0]   be_i,
  output logic                rvalid_o,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_CH-1:0]   start_o,
  output logic [31:0]         start_cfg_o,
  output logic [BUS_W-1:0]    start_bytes_o,
  output logic [BUS_W-1:0]    start_dst_o,
  output logic [BUS_W-1:0]    start_src_o,
  input  logic                upd_valid_i,
  input  logic [IDX_W-1:0]    upd_ch_i,
  input  logic [31:0]         upd_cfg_i,
  input  logic [BUS_W-1:0]    upd_bytes_i,
  input  logic [BUS_W-1:0]    upd_dst_i,
  input  logic [BUS_W-1:0]    upd_src_i,
  input  logic [NUM_CH-1:0]   done_i,
  input  logic [NUM_CH-1:0]   err_i,
  output logic [2*NUM_CH-1:0] irq_o
);
  logic [CH_W-1:0]   sel_ch;
  logic [OFF_W-1:0]  off;
  logic              ch_ok;
  logic [BUS_W-1:0]  rd_ch [NUM_CH];
  desc_t             next_ch [NUM_CH];
  logic [NUM_CH-1:0] start_vec, irq_d, irq_e;
  logic [BUS_W-1:0]  rd_sel;
  desc_t             start_desc, snap_desc, upd_desc;
  logic              rvalid_q;
  logic [BUS_W-1:0]  rdata_q;

  assign sel_ch   = addr_i[ADDR_W-1:12];
  assign off      = addr_i[11:3];
  assign ch_ok    = 32'(sel_ch) < NUM_CH;
  assign upd_desc = '{cfg: upd_cfg_i, bytes: upd_bytes_i, dst: upd_dst_i, src: upd_src_i};

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    logic wr_g, upd_g;
    assign wr_g  = req_i & we_i & ch_ok & (sel_ch == CH_W'(g));
    assign upd_g = upd_valid_i & (upd_ch_i == IDX_W'(g));

    dma_chan_ctl u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_g),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .be_i       (be_i),
      .upd_i      (upd_g),
      .upd_desc_i (upd_desc),
      .done_i     (done_i[g]),
      .err_i      (err_i[g]),
      .next_o     (next_ch[g]),
      .start_o    (start_vec[g]),
      .rdata_o    (rd_ch[g]),
      .irq_done_o (irq_d[g]),
      .irq_err_o  (irq_e[g])
    );

    assign irq_o[2*g]   = irq_d[g];
    assign irq_o[2*g+1] = irq_e[g];
  end

  always_comb begin
    rd_sel     = '0;
    start_desc = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (ch_ok && sel_ch == CH_W'(i)) rd_sel = rd_ch[i];
      if (start_vec[i]) start_desc = next_ch[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i) rdata_q <= rd_sel;
    end
  end

  dma_start_stage #(.NUM_CH(NUM_CH)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_vec),
    .desc_i  (start_desc),
    .start_o (start_o),
    .desc_o  (snap_desc)
  );

  assign rvalid_o      = rvalid_q;
  assign rdata_o       = rdata_q;
  assign start_cfg_o   = snap_desc.cfg;
  assign start_bytes_o = snap_desc.bytes;
  assign start_dst_o   = snap_desc.dst;
  assign start_src_o   = snap_desc.src;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:12]  ch_i,
  input logic                run_bit_i,
  input logic                ctl_lane_i,
  input logic                rvalid_o,
  input logic [63:0]         rdata_o,
  input logic [NUM_CH-1:0]   start_o,
  input logic [NUM_CH-1:0]   done_i,
  input logic [2*NUM_CH-1:0] irq_o
);
  AST_RVALID_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R2
  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o)); // R6
  AST_START_FROM_RUN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> $past(req_i && we_i && run_bit_i && ctl_lane_i)); // R6
  AST_BAD_CH_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && 32'(ch_i) >= NUM_CH) |=> (rdata_o == '0)); // R12
  AST_DONE_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> $past(done_i[0] || (req_i && we_i))); // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .ch_i       (addr_i[ADDR_W-1:12]),
  .run_bit_i  (wdata_i[1]),
  .ctl_lane_i (be_i[0]),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .start_o    (start_o),
  .done_i     (done_i),
  .irq_o      (irq_o)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int NCH = 2;
  localparam int AW  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic           req, we;
  logic [AW-1:3]  addr;
  logic [63:0]    wdata;
  logic [7:0]     be_s;
  logic           rvalid;
  logic [63:0]    rdata;
  logic [NCH-1:0] start;
  logic [31:0]    s_cfg;
  logic [63:0]    s_bytes, s_dst, s_src;
  logic           upd_v;
  logic [0:0]     upd_ch;
  logic [31:0]    upd_cfg;
  logic [63:0]    upd_bytes, upd_dst, upd_src;
  logic [NCH-1:0] done, err;
  logic [2*NCH-1:0] irq;

  dma_chan_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be_s), .rvalid_o(rvalid), .rdata_o(rdata),
    .start_o(start), .start_cfg_o(s_cfg), .start_bytes_o(s_bytes),
    .start_dst_o(s_dst), .start_src_o(s_src), .upd_valid_i(upd_v),
    .upd_ch_i(upd_ch), .upd_cfg_i(upd_cfg), .upd_bytes_i(upd_bytes),
    .upd_dst_i(upd_dst), .upd_src_i(upd_src), .done_i(done), .err_i(err),
    .irq_o(irq)
  );

  int checks = 0, fails = 0, rd_issued = 0, rd_seen = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] e_v;
  string       t_v;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [63:0] d, logic [7:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a[15:3]; wdata = d; be_s = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be_s = '0;
  endtask

  // driver: queue the expected value, then issue the read
  task automatic bus_rd(logic [15:0] a, logic [63:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_issued++;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a[15:3];
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse_done(int ch);
    @(negedge clk); done[ch] = 1'b1;
    @(negedge clk); done = '0;
  endtask

  task automatic pulse_err(int ch);
    @(negedge clk); err[ch] = 1'b1;
    @(negedge clk); err = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R2 rvalid without read", 64'd1, 64'd0);
      end else begin
        e_v = exp_q.pop_front();
        t_v = tag_q.pop_front();
        rd_seen++;
        chk(t_v, rdata, e_v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    req = 0; we = 0; addr = '0; wdata = '0; be_s = '0;
    upd_v = 0; upd_ch = '0; upd_cfg = '0; upd_bytes = '0; upd_dst = '0; upd_src = '0;
    done = '0; err = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 start", 64'(start), 64'd0);
    chk("R1 rvalid", 64'(rvalid), 64'd0);
    bus_rd(16'h0000, 64'h6600_0000_0000_0000, "R1 ctl/cfg");
    bus_rd(16'h0108, 64'h0, "R1 exec bytes");

    // staging and claim
    bus_wr(16'h0008, 64'h100, 8'hFF);
    bus_rd(16'h0008, 64'h100, "R4 bytes write");
    bus_wr(16'h0000, 64'h1, 8'h0F);
    bus_rd(16'h0008, 64'h0, "R3 claim clears bytes");
    bus_rd(16'h0000, 64'h6600_0000_0000_0001, "R3 claim defaults");
    bus_wr(16'h0000, 64'h5500_0004_0000_0000, 8'hF0);
    bus_rd(16'h0000, 64'h5500_0004_0000_0001, "R4 cfg lane write");
    bus_wr(16'h0000, 64'h1, 8'h0F);
    bus_rd(16'h0000, 64'h5500_0004_0000_0001, "R3 reclaim keeps cfg");
    bus_wr(16'h0010, 64'h2000, 8'hFF);
    bus_wr(16'h0018, 64'h1000, 8'hFF);
    bus_wr(16'h0008, 64'hFFFF_FFFF_FFFF_FF40, 8'h01);
    bus_rd(16'h0008, 64'h40, "R4 byte strobe");

    // start
    bus_wr(16'h0000, 64'hC003, 8'h0F);
    chk("R6 start pulse", 64'(start), 64'h1);
    chk("R6 start cfg", 64'(s_cfg), 64'h5500_0004);
    chk("R6 start bytes", s_bytes, 64'h40);
    chk("R6 start dst", s_dst, 64'h2000);
    chk("R6 start src", s_src, 64'h1000);
    bus_rd(16'h0000, 64'h5500_0004_0000_C003, "R6 run set");
    chk("R6 single pulse", 64'(start), 64'h0);
    bus_rd(16'h0110, 64'h2000, "R11 exec dst at start");
    bus_rd(16'h0100, 64'h5500_0004_0000_0000, "R11 exec cfg at start");

    // unclaim while running
    bus_wr(16'h0000, 64'hC002, 8'h0F);
    chk("R7 no restart", 64'(start), 64'h0);
    bus_rd(16'h0000, 64'h5500_0004_0000_C003, "R7 claim kept");

    // engine mirror update
    @(negedge clk);
    upd_v = 1; upd_ch = 1'b0; upd_cfg = 32'h5500_0004;
    upd_bytes = 64'h20; upd_dst = 64'h2020; upd_src = 64'h1020;
    @(negedge clk);
    upd_v = 0;
    bus_rd(16'h0108, 64'h20, "R11 exec bytes update");
    bus_wr(16'h0108, 64'hDEAD, 8'hFF);
    bus_rd(16'h0108, 64'h20, "R11 exec write ignored");
    bus_rd(16'h0118, 64'h1020, "R11 exec src update");

    // done / error
    chk("R10 irq idle", 64'(irq), 64'h0);
    pulse_done(0);
    chk("R10 done irq", 64'(irq), 64'h1);
    bus_rd(16'h0000, 64'h5500_0004_4000_C001, "R9 done status");
    bus_wr(16'h0000, 64'hC003, 8'h0F);
    chk("R6 restart pulse", 64'(start), 64'h1);
    chk("R10 done cleared on start", 64'(irq), 64'h0);
    bus_rd(16'h0000, 64'h5500_0004_0000_C003, "R6 status cleared");
    pulse_err(0);
    chk("R10 err irq", 64'(irq), 64'h2);
    bus_rd(16'h0000, 64'h5500_0004_8000_C001, "R9 err status");
    bus_wr(16'h0000, 64'h8000_0001, 8'h0F);
    chk("R10 err enable off", 64'(irq), 64'h0);
    bus_rd(16'h0000, 64'h5500_0004_8000_0001, "R10 status kept");

    // release and unclaimed writes
    bus_wr(16'h0000, 64'h0, 8'h0F);
    bus_rd(16'h0000, 64'h5500_0004_0000_0000, "R8 release idle");
    bus_wr(16'h0000, 64'h2, 8'h0F);
    chk("R5 no start unclaimed", 64'(start), 64'h0);
    bus_rd(16'h0000, 64'h5500_0004_0000_0000, "R5 run dropped");
    bus_wr(16'h0000, 64'h3, 8'h0F);
    chk("R5 claim+run no start", 64'(start), 64'h0);
    bus_rd(16'h0000, 64'h6600_0000_0000_0001, "R5 claim only");

    // channel 1
    bus_wr(16'h1000, 64'h1, 8'h0F);
    bus_wr(16'h1008, 64'h8, 8'hFF);
    bus_wr(16'h1000, 64'h4003, 8'h0F);
    chk("R6 ch1 start", 64'(start), 64'h2);
    chk("R6 ch1 bytes", s_bytes, 64'h8);
    chk("R6 ch1 cfg", 64'(s_cfg), 64'h6600_0000);
    pulse_done(1);
    chk("R10 ch1 done line", 64'(irq), 64'h4);

    // stray accesses
    bus_rd(16'h2000, 64'h0, "R12 bad channel read");
    bus_wr(16'h2008, 64'h5, 8'hFF);
    bus_rd(16'h2008, 64'h0, "R12 bad channel write");
    bus_wr(16'h0020, 64'h77, 8'hFF);
    bus_rd(16'h0020, 64'h0, "R12 unmapped offset");
    bus_rd(16'h0008, 64'h0, "R12 ch0 untouched");
    bus_rd(16'h1008, 64'h8, "R12 ch1 untouched");

    repeat (3) @(negedge clk);
    chk("R2 all reads returned", 64'(rd_seen), 64'(rd_issued));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule